// File: doc/BRIEF.md
# I2C Slave Address Recogniser

This block listens to the two lines of an I2C bus as a slave device. It finds START, repeated START and STOP conditions and collects the first byte that follows each START. It then decides whether that byte selects this device. A selection comes either from a programmable 7-bit own address, where a per-bit mask may exclude bits from the comparison, or from the all-zero general-call address when that kind of recognition is switched on.

When the byte selects the device, the block pulls SDA low for the whole ninth clock as the acknowledge. When that clock ends it gives a one-cycle hit pulse together with the transfer direction and a flag that tells a general-call hit apart from an own-address hit. It then holds a selected level until the next START or STOP, so that a data-phase engine can take over. When the byte does not select the device, SDA stays released and the block waits for the next START.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, sda_pull_o, hit_o and selected_o are all 0.
- R2: When address bits 7:1 of the first byte after START equal own_addr_i (mask 0), sda_pull_o holds SDA low while SCL is high in the ninth clock. After that clock falls, hit_o pulses for one cycle.
- R3: A first byte whose address field differs from own_addr_i in an unmasked bit leaves SDA released in the ninth clock. It produces no hit_o, and selected_o stays 0.
- R4: Address bits whose addr_mask_i bit is 1 are excluded from the comparison. A byte that differs from own_addr_i only in masked bits is acknowledged.
- R5: With gc_en_i = 1, an address field of 0000000 is acknowledged and reported with hit_gc_o = 1. A hit with hit_gc_o = 1 never happens while gc_en_i = 0.
- R6: With gc_en_i = 0, an address field of 0000000 is not acknowledged unless own_addr_i and addr_mask_i match it.
- R7: hit_rw_o reports bit 0 of the first byte (1 = read, 0 = write), and hit_gc_o = 0 for an own-address hit. Both are valid from the hit_o pulse until the next hit.
- R8: A repeated START in the middle of the address byte discards the bits collected so far. The byte that follows it is judged on its own.
- R9: A STOP releases SDA, clears selected_o and aborts any address byte in progress. Clocks after a STOP and before the next START are never acknowledged.
- R10: sda_pull_o changes only just after a detected falling edge of SCL. SDA is released again in the SCL low phase that follows the ninth clock.
- R11: selected_o rises together with hit_o and stays high until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| own_addr_i | input | 7 | Own 7-bit slave address |
| addr_mask_i | input | 7 | 1 in a bit excludes that address bit from the comparison |
| gc_en_i | input | 1 | Enables recognition of the general-call address |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| hit_o | output | 1 | One-cycle pulse at the end of an acknowledged address byte |
| hit_rw_o | output | 1 | Direction bit of the last hit (1 = read) |
| hit_gc_o | output | 1 | Last hit came from the general call |
| selected_o | output | 1 | Device is addressed until the next START or STOP |

## Verification
A bit counter that has slipped by one makes the acknowledge land in the eighth or the tenth clock. The bench sees this in the very transfer that goes wrong, because it samples SDA in the middle of the ninth high phase. A comparison or mask fault shows up as an acknowledge on the wrong byte, or none on the right one. A wrong captured direction or source flag appears at the hit pulse, a few system cycles after the ninth clock falls. A state that is not cleared by STOP or repeated START shows up as a stray acknowledge or as selected_o staying high within the next bus transaction.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    typedef enum logic [1:0] {
        AM_IDLE,
        AM_ADDR,
        AM_CMP,
        AM_ACK
    } am_state_e;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s_i;
            sda_p_q <= sda_s_i;
        end
    end

    assign start_o = scl_s_i & scl_p_q & sda_p_q & ~sda_s_i;
    assign stop_o  = scl_s_i & scl_p_q & ~sda_p_q & sda_s_i;
    assign rise_o  = scl_s_i & ~scl_p_q;
    assign fall_o  = ~scl_s_i & scl_p_q;
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] own_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic              gc_en_i,
    output logic              own_hit_o,
    output logic              gc_hit_o
);
    assign own_hit_o = ((addr_i ^ own_i) & ~mask_i) == '0;
    assign gc_hit_o  = gc_en_i && (addr_i == '0);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] addr_mask_i,
    input  logic              gc_en_i,
    output logic              sda_pull_o,
    output logic              hit_o,
    output logic              hit_rw_o,
    output logic              hit_gc_o,
    output logic              selected_o
);
    import i2c_am_pkg::*;

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        am_state_e         st;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              pull;
        logic              hit;
        logic              rw;
        logic              gc;
        logic              sel;
    } am_regs_t;

    am_regs_t r_d, r_q;

    // pad synchronisers: index 0 = SCL, index 1 = SDA
    logic [1:0] pad_w, sync_w;
    assign pad_w = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (pad_w[g]),
            .q_o  (sync_w[g])
        );
    end

    logic start_w, stop_w, rise_w, fall_w;

    i2c_am_cond u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s_i(sync_w[0]),
        .sda_s_i(sync_w[1]),
        .start_o(start_w),
        .stop_o (stop_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    logic own_hit_w, gc_hit_w;

    i2c_am_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr_i   (r_q.shreg[BYTE_W-1:1]),
        .own_i    (own_addr_i),
        .mask_i   (addr_mask_i),
        .gc_en_i  (gc_en_i),
        .own_hit_o(own_hit_w),
        .gc_hit_o (gc_hit_w)
    );

    always_comb begin
        r_d     = r_q;
        r_d.hit = 1'b0;
        if (start_w) begin
            r_d.st   = AM_ADDR;
            r_d.cnt  = '0;
            r_d.pull = 1'b0;
            r_d.sel  = 1'b0;
        end else if (stop_w) begin
            r_d.st   = AM_IDLE;
            r_d.pull = 1'b0;
            r_d.sel  = 1'b0;
        end else begin
            unique case (r_q.st)
                AM_ADDR: begin
                    if (rise_w) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sync_w[1]};
                        r_d.cnt   = r_q.cnt + 1'b1;
                        if (r_q.cnt == LAST_BIT) r_d.st = AM_CMP;
                    end
                end
                AM_CMP: begin
                    if (fall_w) begin
                        if (own_hit_w || gc_hit_w) begin
                            r_d.st   = AM_ACK;
                            r_d.pull = 1'b1;
                        end else begin
                            r_d.st = AM_IDLE;
                        end
                    end
                end
                AM_ACK: begin
                    if (fall_w) begin
                        r_d.st   = AM_IDLE;
                        r_d.pull = 1'b0;
                        r_d.hit  = 1'b1;
                        r_d.rw   = r_q.shreg[0];
                        r_d.gc   = gc_hit_w;
                        r_d.sel  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= AM_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o = r_q.pull;
    assign hit_o      = r_q.hit;
    assign hit_rw_o   = r_q.rw;
    assign hit_gc_o   = r_q.gc;
    assign selected_o = r_q.sel;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_pull,
    input logic hit,
    input logic hit_gc,
    input logic gc_en,
    input logic selected,
    input logic stop_seen,
    input logic scl_fall
);
    p_hit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    p_hit_after_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(sda_pull));

    p_gc_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_gc) |-> gc_en);

    p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (!sda_pull && !selected));

    p_pull_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_pull (sda_pull_o),
    .hit      (hit_o),
    .hit_gc   (hit_gc_o),
    .gc_en    (gc_en_i),
    .selected (selected_o),
    .stop_seen(stop_w),
    .scl_fall (fall_w)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb_top;
    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [6:0] own_addr = 7'h3A;
    logic [6:0] mask = 7'h00;
    logic       gc_en = 1'b0;
    logic       sda_pull, hit, hit_rw, hit_gc, selected;
    logic       sda_line;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [1:0] exp_q[$];

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    i2c_addr_match dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .own_addr_i (own_addr),
        .addr_mask_i(mask),
        .gc_en_i    (gc_en),
        .sda_pull_o (sda_pull),
        .hit_o      (hit),
        .hit_rw_o   (hit_rw),
        .hit_gc_o   (hit_gc),
        .selected_o (selected)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected {rw,gc} on each hit pulse (R2, R5, R7)
    always @(negedge clk) begin
        if (rst_n && hit) begin
            checks++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R3 unexpected hit actual=%0b%0b expected=none", hit_rw, hit_gc);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                if ({hit_rw, hit_gc} !== e) begin
                    bad++;
                    $display("FAIL R7 hit flags actual=%0b%0b expected=%0b%0b",
                             hit_rw, hit_gc, e[1], e[0]);
                end
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b1; wait_clk(HALF);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        m_sda = b; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF / 2);
        seen = sda_line; wait_clk(HALF / 2);
        m_scl = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n, output logic ack_seen);
        logic s;
        for (int i = 7; i > 7 - n; i--) bus_bit(v[i], s);
        bus_bit(1'b1, s);
        ack_seen = ~s;
    endtask

    // full address transaction; START (or repeated START), byte, ninth clock
    task automatic xfer(input logic [6:0] a, input logic rw, input logic exp_ack,
                        input logic exp_gc, input bit do_stop, input string req);
        logic ack;
        bus_start();
        if (exp_ack) exp_q.push_back({rw, exp_gc});
        send_bits({a, rw}, 8, ack);
        check({req, " ack in ninth clock"}, 8'(ack), 8'(exp_ack));
        wait_clk(10);
        check({"R10 ", req, " SDA released after ninth"}, 8'(sda_line), 8'h1);
        check({"R11 ", req, " selected"}, 8'(selected), 8'(exp_ack));
        if (do_stop) begin
            bus_stop();
            wait_clk(10);
            check({"R9 ", req, " selected after STOP"}, 8'(selected), 8'h0);
        end
    endtask

    initial begin
        logic ack;
        wait_clk(5);
        check("R1 pull at reset", 8'(sda_pull), 8'h0);
        check("R1 hit at reset", 8'(hit), 8'h0);
        check("R1 selected at reset", 8'(selected), 8'h0);
        rst_n = 1'b1;
        wait_clk(10);

        xfer(7'h3A, 1'b0, 1'b1, 1'b0, 1, "R2 exact write");
        xfer(7'h3A, 1'b1, 1'b1, 1'b0, 1, "R7 exact read");
        xfer(7'h3B, 1'b0, 1'b0, 1'b0, 1, "R3 mismatch lsb");
        xfer(7'h7A, 1'b1, 1'b0, 1'b0, 1, "R3 mismatch msb");

        mask = 7'h03;
        xfer(7'h39, 1'b0, 1'b1, 1'b0, 1, "R4 masked bits differ");
        xfer(7'h3C, 1'b0, 1'b0, 1'b0, 1, "R4 unmasked bit differs");
        mask = 7'h00;

        xfer(7'h00, 1'b0, 1'b0, 1'b0, 1, "R6 general call disabled");
        gc_en = 1'b1;
        xfer(7'h00, 1'b0, 1'b1, 1'b1, 1, "R5 general call enabled");
        xfer(7'h3A, 1'b0, 1'b1, 1'b0, 1, "R7 own hit with gc enabled");
        gc_en = 1'b0;

        // R8: repeated START after four bits, then a valid address byte
        bus_start();
        begin
            logic s;
            for (int i = 0; i < 4; i++) bus_bit(i[0], s);
        end
        check("R8 no pull mid byte", 8'(sda_pull), 8'h0);
        xfer(7'h3A, 1'b1, 1'b1, 1'b0, 0, "R8 after repeated START");
        // R11: repeated START clears selection
        bus_start();
        wait_clk(4);
        check("R11 selected cleared by START", 8'(selected), 8'h0);
        bus_stop();

        // R9: STOP in mid byte, then clocks without START are ignored
        bus_start();
        begin
            logic s;
            for (int i = 0; i < 5; i++) bus_bit(1'b0, s);
        end
        bus_stop();
        m_scl = 1'b0;
        wait_clk(HALF);
        send_bits({7'h3A, 1'b0}, 8, ack);
        check("R9 no ack without START", 8'(ack), 8'h0);
        m_sda = 1'b1; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);

        wait_clk(50);
        check("R2 all expected hits seen", 8'(exp_q.size()), 8'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule